// File: doc/BRIEF.md
# Watchdog Timer with Selectable Reset Scope

This block is a watchdog for a system controller. Software programs a reload value, a pulse width, a reset scope and an optional per-peripheral mask through a small word-addressed register file. It then arms the counter by writing a fixed 16-bit key to the restart word. While enabled, the counter steps down once per tick. The tick is either every clock cycle or a one-cycle strobe from an external 1 MHz timebase. If software fails to restart the counter in time, the counter expires.

On expiry the block clears its own enable bit and records the event in a sticky status word. If reset generation is enabled, it also drives a reset pulse lasting a programmed number of ticks. The pulse goes to the SoC, full-chip or CPU output, or to a vector of per-peripheral resets. Software can poll the enable bit to learn that the reset has completed. A write to the clear word wipes the status.

Top module: `wdog_timer`

## Requirements
- R1: After reset: control reads 0, count and reload read 0x0000FFFF, status, width and mask read 0, and all reset outputs are low.
- R2: A write of exactly 0x00004755 to word 2 loads the reload value into the counter on that write's clock edge; any other value written to word 2 leaves the count unchanged.
- R3: While control bit 0 is set, the count drops by one per tick. When control bit 4 is 0 a tick is every clock cycle; when it is 1 a tick is each cycle with `tick_1m` high.
- R4: A tick taken while the count is 1 or 0 expires the counter: on that edge the count becomes 0 and control bit 0 is cleared. A reload of N (N at least 1) therefore expires on the Nth tick after enabling, and a reload of 0 expires on the first tick.
- R5: Status (word 4) bit 0 is set on expiry and stays set. Bits 15:8 count expiries, saturating at 255. Bit 1 is set if control bit 7 was set at expiry. Any write to word 5 clears all status fields.
- R6: When control bit 1 is set at expiry, the selected reset output goes high from the expiry edge for max(width,1) ticks, where width is word 6. When control bit 1 is clear, no reset output moves.
- R7: Control bits 6:5 choose the scope. Value 0 drives `rst_soc` when the mask is zero, or drives `rst_periph` equal to the mask (and leaves `rst_soc` low) when the mask is nonzero. Value 1 drives `rst_chip`, value 2 drives `rst_cpu`, and value 3 drives nothing. Scope and mask are captured at expiry, and at most one output group is ever active.
- R8: Clearing control bit 0 stops counting. The count holds its value and no expiry occurs while the bit is clear.
- R9: Word map: 0 count (read-only, writes ignored), 1 reload, 2 restart, 3 control, 4 status, 5 clear, 6 width, 7 mask. Control reads back bits 0, 1, 4, 5, 6 and 7 and returns 0 elsewhere. The mask reads back bits 25:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1m | input | 1 | One-cycle strobe from the 1 MHz timebase |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rst_soc | output | 1 | SoC reset pulse |
| rst_chip | output | 1 | Full-chip reset pulse |
| rst_cpu | output | 1 | CPU-only reset pulse |
| rst_periph | output | 26 | Per-peripheral reset pulses |

## Verification
A restart or register write takes effect on the clock edge that samples it. The new count, control and status values are therefore readable at the falling edge that follows. With clock ticks, an enable written on edge C makes the counter expire on edge C+N. The reset output then rises on that same edge and falls on edge C+N+W. The bench drives and samples only at falling edges and counts whole cycles from the last write, so each check reads the value settled by the edge just before it. In strobe mode, the bench issues each tick as one isolated cycle and checks that nothing moves between strobes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int REG_W = 32;
  localparam int STC_W = 8;
  localparam logic [REG_W-1:0] KICK_KEY = 32'h0000_4755;

  typedef enum logic [2:0] {
    A_COUNT  = 3'd0,
    A_RELOAD = 3'd1,
    A_KICK   = 3'd2,
    A_CTRL   = 3'd3,
    A_STAT   = 3'd4,
    A_CLR    = 3'd5,
    A_WIDTH  = 3'd6,
    A_MASK   = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    SCOPE_SOC  = 2'd0,
    SCOPE_CHIP = 2'd1,
    SCOPE_CPU  = 2'd2,
    SCOPE_NONE = 2'd3
  } scope_e;

  typedef struct packed {
    logic   boot2;
    scope_e scope;
    logic   tick_ext;
    logic   rst_en;
    logic   en;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.en       = w[0];
    c.rst_en   = w[1];
    c.tick_ext = w[4];
    c.scope    = scope_e'(w[6:5]);
    c.boot2    = w[7];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_W-1:0] w;
    w      = '0;
    w[0]   = c.en;
    w[1]   = c.rst_en;
    w[4]   = c.tick_ext;
    w[6:5] = c.scope;
    w[7]   = c.boot2;
    return w;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int WID_W  = 16,
  parameter int MASK_W = 26,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [WID_W-1:0]  width_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              kick_o
);

  localparam logic [STC_W-1:0] STC_MAX = '1;

  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic [WID_W-1:0]  width_q, width_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              hit_q, hit_d;
  logic              boot_q, boot_d;
  logic [STC_W-1:0]  stc_q, stc_d;

  logic wr_reload, wr_ctrl, wr_clr, wr_width, wr_mask;

  always_comb begin
    wr_reload = reg_wr && (reg_addr == A_RELOAD);
    wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    wr_clr    = reg_wr && (reg_addr == A_CLR);
    wr_width  = reg_wr && (reg_addr == A_WIDTH);
    wr_mask   = reg_wr && (reg_addr == A_MASK);
    kick_o    = reg_wr && (reg_addr == A_KICK) && (reg_wdata == KICK_KEY);
  end

  // next state
  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    width_d  = width_q;
    mask_d   = mask_q;
    hit_d    = hit_q;
    boot_d   = boot_q;
    stc_d    = stc_q;

    if (wr_ctrl)   ctrl_d   = ctrl_unpack(reg_wdata);
    if (wr_reload) reload_d = reg_wdata[CNT_W-1:0];
    if (wr_width)  width_d  = reg_wdata[WID_W-1:0];
    if (wr_mask)   mask_d   = reg_wdata[MASK_W-1:0];

    if (wr_clr) begin
      hit_d  = 1'b0;
      boot_d = 1'b0;
      stc_d  = '0;
    end

    // hardware update on expiry takes precedence over software
    if (expire_i) begin
      ctrl_d.en = 1'b0;
      hit_d     = 1'b1;
      boot_d    = boot_d | ctrl_q.boot2;
      if (stc_d != STC_MAX) stc_d = stc_d + 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= RELOAD_RST;
      width_q  <= '0;
      mask_q   <= '0;
      hit_q    <= 1'b0;
      boot_q   <= 1'b0;
      stc_q    <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      width_q  <= width_d;
      mask_q   <= mask_d;
      hit_q    <= hit_d;
      boot_q   <= boot_d;
      stc_q    <= stc_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_COUNT:  reg_rdata[CNT_W-1:0]  = count_i;
      A_RELOAD: reg_rdata[CNT_W-1:0]  = reload_q;
      A_CTRL:   reg_rdata             = ctrl_pack(ctrl_q);
      A_STAT: begin
        reg_rdata[0]         = hit_q;
        reg_rdata[1]         = boot_q;
        reg_rdata[8 +: STC_W] = stc_q;
      end
      A_WIDTH:  reg_rdata[WID_W-1:0]  = width_q;
      A_MASK:   reg_rdata[MASK_W-1:0] = mask_q;
      default:  reg_rdata             = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign width_o  = width_q;
  assign mask_o   = mask_q;

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h0000_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;
  logic             last;

  always_comb begin
    step     = run_i && tick_i && !load_i;
    last     = (cnt_q <= ONE);
    expire_o = step && last;

    cnt_d = cnt_q;
    if (load_i)       cnt_d = reload_i;
    else if (step)    cnt_d = last ? '0 : cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD_RST;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int WID_W  = 16,
  parameter int MASK_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              tick_i,
  input  logic [WID_W-1:0]  width_i,
  input  scope_e            scope_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              rst_soc_o,
  output logic              rst_chip_o,
  output logic              rst_cpu_o,
  output logic [MASK_W-1:0] rst_periph_o
);

  localparam logic [WID_W-1:0] W_ONE = WID_W'(1);

  logic              act_q, act_d;
  logic [WID_W-1:0]  left_q, left_d;
  scope_e            scope_q, scope_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              soc_grp;

  always_comb begin
    act_d   = act_q;
    left_d  = left_q;
    scope_d = scope_q;
    mask_d  = mask_q;
    if (fire_i) begin
      act_d   = 1'b1;
      left_d  = (width_i == '0) ? W_ONE : width_i;
      scope_d = scope_i;
      mask_d  = mask_i;
    end else if (act_q && tick_i) begin
      if (left_q <= W_ONE) act_d = 1'b0;
      else                 left_d = left_q - W_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      left_q  <= '0;
      scope_q <= SCOPE_SOC;
      mask_q  <= '0;
    end else begin
      act_q   <= act_d;
      left_q  <= left_d;
      scope_q <= scope_d;
      mask_q  <= mask_d;
    end
  end

  assign soc_grp    = act_q && (scope_q == SCOPE_SOC);
  assign rst_soc_o  = soc_grp && (mask_q == '0);
  assign rst_chip_o = act_q && (scope_q == SCOPE_CHIP);
  assign rst_cpu_o  = act_q && (scope_q == SCOPE_CPU);

  for (genvar i = 0; i < MASK_W; i++) begin : g_periph
    assign rst_periph_o[i] = soc_grp && mask_q[i];
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int WID_W  = 16,
  parameter int MASK_W = 26,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1m,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              rst_soc,
  output logic              rst_chip,
  output logic              rst_cpu,
  output logic [MASK_W-1:0] rst_periph
);

  ctrl_t             ctrl_w;
  logic [CNT_W-1:0]  count_w;
  logic [CNT_W-1:0]  reload_w;
  logic [WID_W-1:0]  width_w;
  logic [MASK_W-1:0] mask_w;
  logic              kick_w;
  logic              expire_w;
  logic              fire_w;
  logic              tick_w;
  logic              run_w;

  assign tick_w = ctrl_w.tick_ext ? tick_1m : 1'b1;
  assign run_w  = ctrl_w.en;
  assign fire_w = expire_w && ctrl_w.rst_en;

  wdog_regs #(
    .CNT_W(CNT_W), .WID_W(WID_W), .MASK_W(MASK_W), .RELOAD_RST(RELOAD_RST)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .count_i(count_w), .expire_i(expire_w),
    .ctrl_o(ctrl_w), .reload_o(reload_w), .width_o(width_w),
    .mask_o(mask_w), .kick_o(kick_w)
  );

  wdog_count #(
    .CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)
  ) count_i (
    .clk(clk), .rst_n(rst_n),
    .run_i(run_w), .tick_i(tick_w), .load_i(kick_w),
    .reload_i(reload_w), .count_o(count_w), .expire_o(expire_w)
  );

  wdog_pulse #(
    .WID_W(WID_W), .MASK_W(MASK_W)
  ) pulse_i (
    .clk(clk), .rst_n(rst_n),
    .fire_i(fire_w), .tick_i(tick_w), .width_i(width_w),
    .scope_i(ctrl_w.scope), .mask_i(mask_w),
    .rst_soc_o(rst_soc), .rst_chip_o(rst_chip), .rst_cpu_o(rst_cpu),
    .rst_periph_o(rst_periph)
  );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int MASK_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              run,
  input logic              tick,
  input logic              expire,
  input logic              fire,
  input logic              rst_soc,
  input logic              rst_chip,
  input logic              rst_cpu,
  input logic [MASK_W-1:0] rst_periph
);

  logic kick_seen;
  logic kick_port;
  logic any_rst;

  assign kick_port = reg_wr && (reg_addr == 3'd2);
  assign kick_seen = kick_port && (reg_wdata == 32'h0000_4755);
  assign any_rst   = rst_soc | rst_chip | rst_cpu | (|rst_periph);

  p_key_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kick_seen |=> (count == $past(reload)));

  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_port && !kick_seen && !run) |=> $stable(count));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !kick_port && (count > CNT_W'(1))) |=> (count == $past(count) - CNT_W'(1)));

  p_expire_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!run && (count == '0)));

  p_pulse_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_rst) |-> $past(fire));

  p_one_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_soc, rst_chip, rst_cpu, |rst_periph}));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !kick_seen) |=> $stable(count));

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .MASK_W(MASK_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .count(count_w), .reload(reload_w), .run(run_w), .tick(tick_w),
  .expire(expire_w), .fire(fire_w),
  .rst_soc(rst_soc), .rst_chip(rst_chip), .rst_cpu(rst_cpu),
  .rst_periph(rst_periph)
);

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;

  localparam logic [2:0] W_COUNT = 3'd0, W_RELOAD = 3'd1, W_KICK = 3'd2, W_CTRL = 3'd3,
                         W_STAT = 3'd4, W_CLR = 3'd5, W_WIDTH = 3'd6, W_MASK = 3'd7;
  localparam logic [31:0] KEY = 32'h0000_4755;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_1m;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        rst_soc, rst_chip, rst_cpu;
  logic [25:0] rst_periph;
  logic [3:0]  outs;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assign outs = {rst_soc, rst_chip, rst_cpu, |rst_periph};

  wdog_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1m(tick_1m),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .rst_soc(rst_soc), .rst_chip(rst_chip), .rst_cpu(rst_cpu),
    .rst_periph(rst_periph)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic tick_pulse();
    @(negedge clk); tick_1m = 1'b1;
    @(negedge clk); tick_1m = 1'b0;
  endtask

  // kick while disabled, then enable: counting starts after the control write
  task automatic arm(input logic [31:0] rl, input logic [31:0] w,
                     input logic [31:0] m, input logic [31:0] c);
    wr(W_RELOAD, rl);
    wr(W_WIDTH, w);
    wr(W_MASK, m);
    wr(W_KICK, KEY);
    wr(W_CTRL, c);
  endtask

  task automatic t_reset();
    chk_reg("R1 ctrl", W_CTRL, 32'h0);
    chk_reg("R1 count", W_COUNT, 32'h0000_FFFF);
    chk_reg("R1 reload", W_RELOAD, 32'h0000_FFFF);
    chk_reg("R1 status", W_STAT, 32'h0);
    chk_reg("R1 width", W_WIDTH, 32'h0);
    chk_reg("R1 mask", W_MASK, 32'h0);
    chk("R1 outs", {28'h0, outs}, 32'h0);
  endtask

  task automatic t_key();
    wr(W_RELOAD, 32'd7);
    wr(W_KICK, 32'h0000_4756);
    chk_reg("R2 wrong key ignored", W_COUNT, 32'h0000_FFFF);
    wr(W_KICK, 32'h0001_4755);
    chk_reg("R2 upper bits ignored", W_COUNT, 32'h0000_FFFF);
    wr(W_KICK, KEY);
    chk_reg("R2 key loads", W_COUNT, 32'd7);
    wr(W_COUNT, 32'h1234);
    chk_reg("R9 count read-only", W_COUNT, 32'd7);
  endtask

  task automatic t_readback();
    wr(W_CTRL, 32'hFFFF_FFFC);
    chk_reg("R9 ctrl readback", W_CTRL, 32'h0000_00F0);
    wr(W_CTRL, 32'h0);
    wr(W_MASK, 32'hFFFF_FFFF);
    chk_reg("R9 mask readback", W_MASK, 32'h03FF_FFFF);
    wr(W_MASK, 32'h0);
  endtask

  task automatic t_chip();
    arm(32'd5, 32'd3, 32'h0, 32'h23);
    chk_reg("R3 start count", W_COUNT, 32'd5);
    cyc(4);
    chk_reg("R3 count before expiry", W_COUNT, 32'd1);
    chk("R6 no early pulse", {28'h0, outs}, 32'h0);
    cyc(1);
    chk("R7 chip pulse", {28'h0, outs}, 32'h4);
    chk_reg("R4 enable cleared", W_CTRL, 32'h22);
    chk_reg("R4 count zero", W_COUNT, 32'h0);
    chk_reg("R5 status set", W_STAT, 32'h0000_0101);
    cyc(2);
    chk("R6 pulse held", {28'h0, outs}, 32'h4);
    cyc(1);
    chk("R6 pulse released", {28'h0, outs}, 32'h0);
  endtask

  task automatic t_clear();
    wr(W_CLR, 32'h0);
    chk_reg("R5 status cleared", W_STAT, 32'h0);
  endtask

  task automatic t_cpu();
    arm(32'd2, 32'd1, 32'h0, 32'h43);
    cyc(1);
    chk("R7 cpu idle", {28'h0, outs}, 32'h0);
    cyc(1);
    chk("R7 cpu pulse", {28'h0, outs}, 32'h2);
    cyc(1);
    chk("R6 cpu width 1", {28'h0, outs}, 32'h0);
  endtask

  task automatic t_soc();
    arm(32'd3, 32'd2, 32'h0, 32'h03);
    cyc(3);
    chk("R7 soc pulse", {28'h0, outs}, 32'h8);
    cyc(1);
    chk("R7 soc held", {28'h0, outs}, 32'h8);
    cyc(1);
    chk("R6 soc released", {28'h0, outs}, 32'h0);
  endtask

  task automatic t_periph();
    logic [31:0] v;
    arm(32'd2, 32'd4, 32'h15, 32'h03);
    cyc(2);
    chk("R7 periph group only", {28'h0, outs}, 32'h1);
    chk("R7 periph vector", {6'h0, rst_periph}, 32'h15);
    wr(W_MASK, 32'h0);
    rd(W_MASK, v);
    chk("R7 mask rewritten", v, 32'h0);
    chk("R7 mask captured at expiry", {6'h0, rst_periph}, 32'h15);
    cyc(2);
    chk("R6 periph released", {6'h0, rst_periph}, 32'h0);
  endtask

  task automatic t_none();
    arm(32'd1, 32'd2, 32'h0, 32'h63);
    cyc(1);
    chk("R7 scope 3 drives nothing", {28'h0, outs}, 32'h0);
    chk_reg("R4 enable cleared scope 3", W_CTRL, 32'h62);
    cyc(1);
    chk("R7 scope 3 still quiet", {28'h0, outs}, 32'h0);
  endtask

  task automatic t_norst();
    arm(32'd2, 32'd2, 32'h0, 32'h21);
    cyc(2);
    chk("R6 no pulse without bit 1", {28'h0, outs}, 32'h0);
    chk_reg("R4 enable cleared no-reset", W_CTRL, 32'h20);
    cyc(1);
    chk("R6 still no pulse", {28'h0, outs}, 32'h0);
    chk_reg("R5 count field five", W_STAT, 32'h0000_0501);
  endtask

  task automatic t_boot();
    wr(W_CLR, 32'hDEAD_BEEF);
    arm(32'd1, 32'd1, 32'h0, 32'h81);
    cyc(1);
    chk_reg("R5 boot status bit", W_STAT, 32'h0000_0103);
    chk_reg("R4 boot ctrl", W_CTRL, 32'h80);
  endtask

  task automatic t_width0();
    arm(32'd1, 32'd0, 32'h0, 32'h23);
    cyc(1);
    chk("R6 width 0 pulse", {28'h0, outs}, 32'h4);
    cyc(1);
    chk("R6 width 0 is one tick", {28'h0, outs}, 32'h0);
  endtask

  task automatic t_reload0();
    arm(32'd0, 32'd1, 32'h0, 32'h01);
    chk_reg("R4 reload 0 enabled", W_CTRL, 32'h01);
    cyc(1);
    chk_reg("R4 reload 0 first tick", W_CTRL, 32'h00);
  endtask

  task automatic t_disable();
    arm(32'd20, 32'd1, 32'h0, 32'h23);
    cyc(3);
    chk_reg("R3 counting", W_COUNT, 32'd17);
    wr(W_CTRL, 32'h22);
    chk_reg("R8 stopped", W_COUNT, 32'd15);
    cyc(10);
    chk_reg("R8 count holds", W_COUNT, 32'd15);
    chk("R8 no reset", {28'h0, outs}, 32'h0);
    chk_reg("R8 ctrl", W_CTRL, 32'h22);
  endtask

  task automatic t_tick();
    arm(32'd3, 32'd2, 32'h0, 32'h33);
    chk_reg("R3 ext start", W_COUNT, 32'd3);
    cyc(5);
    chk_reg("R3 no strobe no step", W_COUNT, 32'd3);
    tick_pulse();
    chk_reg("R3 one strobe", W_COUNT, 32'd2);
    cyc(4);
    chk_reg("R3 idle between strobes", W_COUNT, 32'd2);
    tick_pulse();
    tick_pulse();
    chk("R4 expiry on strobe", {28'h0, outs}, 32'h4);
    cyc(5);
    chk("R6 width in strobes", {28'h0, outs}, 32'h4);
    tick_pulse();
    chk("R6 held after one strobe", {28'h0, outs}, 32'h4);
    tick_pulse();
    chk("R6 released after two strobes", {28'h0, outs}, 32'h0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_1m = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_key();
    t_readback();
    t_chip();
    t_clear();
    t_cpu();
    t_soc();
    t_periph();
    t_none();
    t_norst();
    t_boot();
    t_width0();
    t_reload0();
    t_disable();
    t_tick();
    cyc(2);
    finish_run();
  end

endmodule